// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block paces the analog front end of a sampling converter. A 32768 Hz tick enable arrives as a one-cycle strobe in the system clock domain. The block divides time into frames. Each frame holds a programmable number of conversion slots and ends with a short dead interval. During each slot it presents the ADC input handle held in that slot's 4-bit select field. It gives the decimation filter a start strobe as each slot opens and gives the compute engine a start strobe as each frame closes.

The slot length depends on three settings: a 2-bit filter-length code, a half-rate bit and a fast-clock bit. With the fast clock the dead interval is one tick; without it the dead interval is three ticks. A slot count of zero parks the sequencer so that software can reconfigure it. The configuration is taken in only when a frame starts, so a write made part way through a frame never produces a mixed frame. A select code that names no real input is flagged and replaced with handle 0. A reference-chop toggle flips once per frame when chopping is enabled.

Top module: `adc_mux_sequencer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `slot_active`, `handle_bad`, `fir_start`, `ce_start` and `chop` are 0 and `mux_handle` is 0.
- R2: Outputs change only in the cycle that follows a cycle with `tick` high. In any other cycle `fir_start` and `ce_start` are 0.
- R3: With `cfg_fast_clk`=1, each slot lasts (cfg_fir_len+1)*(cfg_half_rate+1) ticks.
- R4: With `cfg_fast_clk`=0, each slot lasts 3*(cfg_fir_len+1)*(cfg_half_rate+1) ticks.
- R5: A frame lasts cfg_slots*slot_length + D ticks, where D is 1 when `cfg_fast_clk`=1 and 3 when it is 0. The dead interval D follows the last slot. `ce_start` is a one-cycle pulse at the end of the dead interval, and the next frame's slot 0 opens on that same edge.
- R6: During slot x (`mux_slot`=x, counted from 0), `mux_handle` equals `cfg_sel[4x+3:4x]` when that value is 10 or less. Outside slots `mux_handle` is 0.
- R7: `fir_start` is a one-cycle pulse when each slot opens, including slot 0.
- R8: If the slot count is 0 when a frame would start, the sequencer stays idle: `slot_active` stays 0 and no pulses are issued. It starts again at slot 0 on the first tick that finds a nonzero count.
- R9: All configuration inputs, including the select bank, are captured only when a frame starts. A change made part way through a frame applies from the next frame.
- R10: A select value above 10 in the active slot raises `handle_bad` and forces `mux_handle` to 0. `handle_bad` is 0 outside slots.
- R11: `chop` inverts together with each `ce_start` if the frame that just ended was captured with `cfg_chop_en`=1. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 32768 Hz enable strobe |
| cfg_slots | input | 4 | Slots per frame; 0 parks the sequencer |
| cfg_fir_len | input | 2 | Filter-length code |
| cfg_half_rate | input | 1 | Doubles the slot length |
| cfg_fast_clk | input | 1 | Fast-clock mode: slot length x1 and dead interval 1, otherwise x3 and 3 |
| cfg_chop_en | input | 1 | Enables the per-frame chop toggle |
| cfg_sel | input | 60 | Select bank, 4 bits per slot, slot 0 in the low bits |
| mux_handle | output | 4 | ADC input handle for the current slot |
| mux_slot | output | 4 | Current slot index |
| slot_active | output | 1 | A slot is in progress |
| handle_bad | output | 1 | The current slot's select value is above 10 |
| fir_start | output | 1 | Filter start pulse |
| ce_start | output | 1 | Compute-engine start pulse |
| chop | output | 1 | Reference chop toggle |

## Verification
The pulse-width assertions rely on `tick` never being high in two consecutive clock cycles. This is true of a 32 kHz strobe in a fast clock domain. The stimulus always puts one to three idle cycles between ticks. Configuration inputs change only on the falling edge, including in the middle of frames, so the capture rule is exercised without races at the clock edge. The select bank is randomized across the full 4-bit range, so that invalid codes 11 to 15 also reach active slots.

// File: rtl/mux_seq_pkg.sv
package mux_seq_pkg;

    localparam int SLOT_W     = 4;
    localparam int HANDLE_W   = 4;
    localparam int FIR_W      = 2;
    localparam int LEN_W      = 5;
    localparam int DEAD_W     = 2;
    localparam int MAX_SLOTS  = (1 << SLOT_W) - 1;
    localparam int SEL_W      = MAX_SLOTS * HANDLE_W;
    localparam int MAX_HANDLE = 10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SLOT = 2'd1,
        PH_DEAD = 2'd2
    } seq_phase_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slots;
        logic [LEN_W-1:0]  slot_len;
        logic [DEAD_W-1:0] dead_len;
        logic              chop_en;
    } frame_cfg_t;

    function automatic logic [LEN_W-1:0] calc_slot_len(
        input logic [FIR_W-1:0] fir_code,
        input logic             half,
        input logic             fast
    );
        logic [LEN_W-1:0] base;
        base = (LEN_W'(fir_code) + LEN_W'(1)) << half;
        return fast ? base : LEN_W'(base * LEN_W'(3));
    endfunction

    function automatic logic [DEAD_W-1:0] calc_dead_len(input logic fast);
        return fast ? DEAD_W'(1) : DEAD_W'(3);
    endfunction

endpackage

// File: rtl/mux_cfg_latch.sv
module mux_cfg_latch
    import mux_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SLOT_W-1:0]    slots_in,
    input  logic [FIR_W-1:0]     fir_in,
    input  logic                 half_in,
    input  logic                 fast_in,
    input  logic                 chop_en_in,
    input  logic [SEL_W-1:0]     sel_in,
    output frame_cfg_t           nxt_cfg,
    output frame_cfg_t           cur_cfg,
    output logic [SEL_W-1:0]     cur_sel
);

    always_comb begin
        nxt_cfg.slots    = slots_in;
        nxt_cfg.slot_len = calc_slot_len(fir_in, half_in, fast_in);
        nxt_cfg.dead_len = calc_dead_len(fast_in);
        nxt_cfg.chop_en  = chop_en_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cfg <= '0;
            cur_sel <= '0;
        end else if (load) begin
            cur_cfg <= nxt_cfg;
            cur_sel <= sel_in;
        end
    end

endmodule

// File: rtl/mux_slot_fsm.sv
module mux_slot_fsm
    import mux_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        nxt_cfg,
    input  frame_cfg_t        cur_cfg,
    output logic              load,
    output logic              slot_active,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              fir_start,
    output logic              ce_start,
    output logic              chop
);

    seq_phase_e       phase;
    logic [LEN_W-1:0] cnt;
    logic             frame_end;

    assign frame_end   = tick && (phase == PH_DEAD) && (cnt == '0);
    assign load        = (tick && (phase == PH_IDLE)) || frame_end;
    assign slot_active = (phase == PH_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            slot_idx  <= '0;
            fir_start <= 1'b0;
            ce_start  <= 1'b0;
            chop      <= 1'b0;
        end else begin
            fir_start <= 1'b0;
            ce_start  <= 1'b0;
            if (tick) begin
                case (phase)
                    PH_IDLE: begin
                        if (nxt_cfg.slots != '0) begin
                            phase     <= PH_SLOT;
                            slot_idx  <= '0;
                            cnt       <= nxt_cfg.slot_len - LEN_W'(1);
                            fir_start <= 1'b1;
                        end
                    end
                    PH_SLOT: begin
                        if (cnt != '0) begin
                            cnt <= cnt - LEN_W'(1);
                        end else if (slot_idx == cur_cfg.slots - SLOT_W'(1)) begin
                            phase <= PH_DEAD;
                            cnt   <= LEN_W'(cur_cfg.dead_len) - LEN_W'(1);
                        end else begin
                            slot_idx  <= slot_idx + SLOT_W'(1);
                            cnt       <= cur_cfg.slot_len - LEN_W'(1);
                            fir_start <= 1'b1;
                        end
                    end
                    PH_DEAD: begin
                        if (cnt != '0) begin
                            cnt <= cnt - LEN_W'(1);
                        end else begin
                            ce_start <= 1'b1;
                            if (cur_cfg.chop_en) chop <= ~chop;
                            if (nxt_cfg.slots != '0) begin
                                phase     <= PH_SLOT;
                                slot_idx  <= '0;
                                cnt       <= nxt_cfg.slot_len - LEN_W'(1);
                                fir_start <= 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R7: filter start is a single-cycle strobe (ticks are never adjacent)
    a_r7_fir_single: assert property (@(posedge clk) disable iff (rst)
        fir_start |=> !fir_start);

    // R5: compute-engine start is a single-cycle strobe
    a_r5_ce_single: assert property (@(posedge clk) disable iff (rst)
        ce_start |=> !ce_start);

    // R2: strobes only follow a tick
    a_r2_pulse_after_tick: assert property (@(posedge clk) disable iff (rst)
        (fir_start || ce_start) |-> $past(tick));

    // R11: chop moves only on a frame boundary
    a_r11_chop_on_frame: assert property (@(posedge clk) disable iff (rst)
        (chop != $past(chop)) |-> ce_start);

    // R5: a continuing frame opens at slot 0
    a_r5_restart_slot0: assert property (@(posedge clk) disable iff (rst)
        (ce_start && slot_active) |-> (slot_idx == '0));

    // R8: the slot index stays below the captured slot count
    a_r8_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        slot_active |-> (slot_idx < cur_cfg.slots));

endmodule

// File: rtl/mux_handle_sel.sv
module mux_handle_sel
    import mux_seq_pkg::*;
(
    input  logic                slot_active,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [SEL_W-1:0]    sel_bank,
    output logic [HANDLE_W-1:0] handle,
    output logic                bad
);

    logic [HANDLE_W-1:0] fields [MAX_SLOTS];
    logic [HANDLE_W-1:0] raw;

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_field
        assign fields[g] = sel_bank[g*HANDLE_W +: HANDLE_W];
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            if (slot_idx == SLOT_W'(i)) raw = fields[i];
        end
    end

    always_comb begin
        bad    = slot_active && (raw > HANDLE_W'(MAX_HANDLE));
        handle = (slot_active && !bad) ? raw : '0;
    end

endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
    import mux_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [SLOT_W-1:0]   cfg_slots,
    input  logic [FIR_W-1:0]    cfg_fir_len,
    input  logic                cfg_half_rate,
    input  logic                cfg_fast_clk,
    input  logic                cfg_chop_en,
    input  logic [SEL_W-1:0]    cfg_sel,
    output logic [HANDLE_W-1:0] mux_handle,
    output logic [SLOT_W-1:0]   mux_slot,
    output logic                slot_active,
    output logic                handle_bad,
    output logic                fir_start,
    output logic                ce_start,
    output logic                chop
);

    frame_cfg_t       nxt_cfg;
    frame_cfg_t       cur_cfg;
    logic [SEL_W-1:0] cur_sel;
    logic             load;

    mux_cfg_latch u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .slots_in   (cfg_slots),
        .fir_in     (cfg_fir_len),
        .half_in    (cfg_half_rate),
        .fast_in    (cfg_fast_clk),
        .chop_en_in (cfg_chop_en),
        .sel_in     (cfg_sel),
        .nxt_cfg    (nxt_cfg),
        .cur_cfg    (cur_cfg),
        .cur_sel    (cur_sel)
    );

    mux_slot_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .nxt_cfg     (nxt_cfg),
        .cur_cfg     (cur_cfg),
        .load        (load),
        .slot_active (slot_active),
        .slot_idx    (mux_slot),
        .fir_start   (fir_start),
        .ce_start    (ce_start),
        .chop        (chop)
    );

    mux_handle_sel u_sel (
        .slot_active (slot_active),
        .slot_idx    (mux_slot),
        .sel_bank    (cur_sel),
        .handle      (mux_handle),
        .bad         (handle_bad)
    );

    // R10: the invalid flag is raised only inside a slot
    a_r10_bad_in_slot: assert property (@(posedge clk) disable iff (rst)
        handle_bad |-> slot_active);

    // R6: outside slots no handle is presented
    a_r6_idle_handle_zero: assert property (@(posedge clk) disable iff (rst)
        !slot_active |-> (mux_handle == '0));

    // R7: every slot opening at an index other than 0 follows a slot that was active
    a_r7_advance_from_slot: assert property (@(posedge clk) disable iff (rst)
        (fir_start && mux_slot != '0) |-> $past(slot_active));

endmodule

// File: tb/tb_adc_mux_sequencer.sv
module tb_adc_mux_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [3:0]  cfg_slots = '0;
    logic [1:0]  cfg_fir_len = '0;
    logic        cfg_half_rate = 1'b0;
    logic        cfg_fast_clk = 1'b0;
    logic        cfg_chop_en = 1'b0;
    logic [59:0] cfg_sel = '0;
    logic [3:0]  mux_handle;
    logic [3:0]  mux_slot;
    logic        slot_active, handle_bad, fir_start, ce_start, chop;

    always #5 clk = ~clk;

    adc_mux_sequencer dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_slots(cfg_slots), .cfg_fir_len(cfg_fir_len),
        .cfg_half_rate(cfg_half_rate), .cfg_fast_clk(cfg_fast_clk),
        .cfg_chop_en(cfg_chop_en), .cfg_sel(cfg_sel),
        .mux_handle(mux_handle), .mux_slot(mux_slot),
        .slot_active(slot_active), .handle_bad(handle_bad),
        .fir_start(fir_start), .ce_start(ce_start), .chop(chop)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state, in ticks since frame start
    bit          m_idle = 1;
    int          m_pos, m_slots, m_len, m_dead;
    bit          m_chop_en, m_chop;
    logic [59:0] m_sel;
    bit          e_fir, e_ce;

    int tick_n = 0, last_fir = 0, last_ce = 0, slot_gap = 0, frame_gap = 0, fir_cnt = 0;

    function automatic int exp_slot_len(int fir, int half, int fast);
        return (fir + 1) * (half + 1) * (fast ? 1 : 3);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic latch_cfg();
        m_slots   = int'(cfg_slots);
        m_len     = exp_slot_len(int'(cfg_fir_len), int'(cfg_half_rate), int'(cfg_fast_clk));
        m_dead    = cfg_fast_clk ? 1 : 3;
        m_chop_en = cfg_chop_en;
        m_sel     = cfg_sel;
    endtask

    task automatic model_tick();
        e_fir = 0; e_ce = 0;
        if (m_idle) begin
            latch_cfg();
            if (m_slots != 0) begin m_idle = 0; m_pos = 0; e_fir = 1; end
        end else begin
            m_pos++;
            if (m_pos == m_slots * m_len + m_dead) begin
                e_ce = 1;
                if (m_chop_en) m_chop = !m_chop;
                latch_cfg();
                if (m_slots != 0) begin m_pos = 0; e_fir = 1; end
                else m_idle = 1;
            end else if (m_pos < m_slots * m_len && m_pos % m_len == 0) begin
                e_fir = 1;
            end
        end
    endtask

    task automatic step(input bit tv, input string htag);
        bit act;
        int s, v;
        tick = tv;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        if (tv) begin model_tick(); tick_n++; end
        else begin e_fir = 0; e_ce = 0; end
        act = !m_idle && (m_pos < m_slots * m_len);
        s = act ? m_pos / m_len : 0;
        v = int'(m_sel[s*4 +: 4]);
        chk(tv ? "R7" : "R2", "fir_start", int'(fir_start), int'(e_fir));
        chk(tv ? "R5" : "R2", "ce_start", int'(ce_start), int'(e_ce));
        chk("R8", "slot_active", int'(slot_active), int'(act));
        if (act) chk(htag, "mux_slot", int'(mux_slot), s);
        chk(htag, "mux_handle", int'(mux_handle), (act && v <= 10) ? v : 0);
        chk("R10", "handle_bad", int'(handle_bad), int'(act && v > 10));
        chk("R11", "chop", int'(chop), int'(m_chop));
        if (fir_start) begin
            fir_cnt++;
            if (mux_slot != 0) slot_gap = tick_n - last_fir;
            last_fir = tick_n;
        end
        if (ce_start) begin
            frame_gap = tick_n - last_ce;
            last_ce = tick_n;
        end
    endtask

    task automatic run(input int nticks, input string htag);
        for (int i = 0; i < nticks; i++) begin
            int gap;
            gap = 1 + int'($urandom_range(2));
            for (int j = 0; j < gap; j++) step(1'b0, htag);
            step(1'b1, htag);
        end
    endtask

    task automatic set_cfg(input int sl, input int fir, input int half, input int fast,
                           input int ce, input logic [59:0] sel);
        cfg_slots = 4'(sl); cfg_fir_len = 2'(fir); cfg_half_rate = 1'(half);
        cfg_fast_clk = 1'(fast); cfg_chop_en = 1'(ce); cfg_sel = sel;
    endtask

    function automatic logic [59:0] rand_sel();
        logic [59:0] r;
        for (int i = 0; i < 15; i++) r[i*4 +: 4] = 4'($urandom_range(15));
        return r;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "slot_active", int'(slot_active), 0);
        chk("R1", "mux_handle", int'(mux_handle), 0);
        chk("R1", "fir_start", int'(fir_start), 0);
        chk("R1", "chop", int'(chop), 0);
        rst = 1'b0;
        step(1'b0, "R1");
        chk("R1", "ce_start", int'(ce_start), 0);
        chk("R1", "handle_bad", int'(handle_bad), 0);

        // R3/R5: fast clock, len (1+1)*(1+1)=4, frame 2*4+1=9
        set_cfg(2, 1, 1, 1, 0, 60'h00000000000_0073);
        run(30, "R6");
        chk("R3", "slot ticks", slot_gap, 4);
        chk("R5", "frame ticks", frame_gap, 9);

        // R4/R5/R11: slow clock, len 3, frame 3*3+3=12, chopping on
        set_cfg(3, 0, 0, 0, 1, 60'h00000000000_0a52);
        run(50, "R6");
        chk("R4", "slot ticks", slot_gap, 3);
        chk("R5", "frame ticks", frame_gap, 12);

        // R8: park, confirm no strobes, then resume at slot 0
        set_cfg(0, 0, 0, 1, 1, 60'h00000000000_0004);
        run(40, "R8");
        fir_cnt = 0;
        run(10, "R8");
        chk("R8", "parked fir count", fir_cnt, 0);
        chk("R8", "parked slot_active", int'(slot_active), 0);
        set_cfg(1, 0, 0, 1, 0, 60'h00000000000_0006);
        run(1, "R8");
        chk("R8", "resume fir_start", int'(fir_start), 1);
        chk("R8", "resume handle", int'(mux_handle), 6);
        run(10, "R8");

        // R9: change everything part way through a frame
        set_cfg(4, 1, 0, 1, 0, 60'h00000000000_4321);
        run(13, "R9");
        set_cfg(2, 0, 1, 0, 1, 60'h00000000000_0098);
        run(2, "R9");
        chk("R9", "old handle kept", int'(mux_handle), int'(m_sel[int'(mux_slot)*4 +: 4]));
        run(40, "R9");

        // R10: invalid select codes in used slots
        set_cfg(3, 0, 0, 1, 0, 60'h00000000000_0f5b);
        run(30, "R10");

        // random configurations
        for (int k = 0; k < 14; k++) begin
            set_cfg(int'($urandom_range(15)), int'($urandom_range(3)), int'($urandom_range(1)),
                    int'($urandom_range(1)), int'($urandom_range(1)), rand_sel());
            run(25 + int'($urandom_range(50)), "R6");
        end

        done = 1;
        finish_run();
    end

endmodule